// File: doc/BRIEF.md
# Selectable-Width Port Word Packer

This block sits between a fixed-width internal word stream and an external port whose data width can be set to the full word, half a word or a quarter word (36, 18 or 9 bits with the default parameters). In the write direction it collects narrow external transfers and assembles them into full internal words. In the read direction it takes one internal word at a time and hands it out as a series of narrow external transfers. Both directions do all width matching inside the block, so the surrounding logic needs no glue.

The width select may change during operation, with no reset. A change made while a direction sits on a word boundary takes effect at once on the next transfer. A change made part-way through a word leaves that direction out of step. The next external transfer in that direction is then treated as a dummy and thrown away, together with the unfinished word, and the direction restarts at the first piece. Each direction tracks its own position and its own realign state.

Top module: `port_width_adapter`

## Requirements
- R1: After reset, `int_out_valid` is 0, `ext_wr_busy` is 0, `int_in_ready` is 1, `ext_rd_busy` is 1 and `ext_rdata` is 0.
- R2: With `wsel` = 2'b00 (full width), each accepted write strobe puts `ext_wdata` on `int_out_data` with `int_out_valid` high from the next clock edge.
- R3: With `wsel` = 2'b01 (half width), the first accepted write fills word bits 17:0 from `ext_wdata[17:0]` and the second fills bits 35:18; `int_out_valid` rises only after the second.
- R4: With `wsel` = 2'b10 (byte width), write piece p (0 to 3) fills word bits 9p+8:9p from `ext_wdata[8:0]`; the word is emitted only after piece 3.
- R5: Reads unpack the held word least-significant piece first: full mode returns the whole word; half mode returns bits 17:0 then 35:18; byte mode returns byte 0 to byte 3; bits above the active width read as 0.
- R6: `ext_rdata` changes on the clock edge that accepts the read strobe. While a word is held, `int_in_ready` is low; a new internal word is taken only after its last piece has been read.
- R7: While `int_out_valid` is high and `int_out_ready` is low, `ext_wr_busy` is high, the pending word and its valid stay unchanged, and write strobes are not accepted.
- R8: A width change made when a direction is at a word boundary needs no dummy transfer: the next transfer uses the new width.
- R9: A width change made while the write side is mid-word makes the next accepted write strobe a dummy: it and the partly built word are discarded, nothing is emitted, and the write side restarts at piece 0.
- R10: A width change made while the read side is mid-word makes the next read strobe a dummy: `ext_rdata` becomes 0, the rest of the held word is discarded and a new internal word may be taken.
- R11: `wsel` = 2'b11 behaves as full width.
- R12: A read strobe while `ext_rd_busy` is high is ignored and `ext_rdata` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wsel | input | 2 | Width select: 00 full, 01 half, 10 byte, 11 full |
| ext_wr | input | 1 | External write strobe |
| ext_wdata | input | WORD_W | External write data, low bits used in narrow modes |
| ext_wr_busy | output | 1 | High when a write strobe will not be accepted |
| int_out_valid | output | 1 | Packed word available on the internal stream |
| int_out_data | output | WORD_W | Packed internal word |
| int_out_ready | input | 1 | Internal consumer accepts the packed word |
| int_in_valid | input | 1 | Internal word offered for unpacking |
| int_in_data | input | WORD_W | Internal word to unpack |
| int_in_ready | output | 1 | Block can take an internal word |
| ext_rd | input | 1 | External read strobe |
| ext_rdata | output | WORD_W | External read data, upper bits zero in narrow modes |
| ext_rd_busy | output | 1 | High when no word is held for reading |

## Verification
The bench builds the block with its default word width of 36, which gives 18-bit halves and 9-bit bytes and so brings all three port widths and the reserved select code within reach. With this setting every piece position of both directions is visited, including the last byte lane, and distinct lane patterns show any misplaced or swapped piece. Width changes are driven both on word boundaries and part-way through half and byte words in each direction, alongside stalls from the internal consumer and reads with no word held.

// File: rtl/pwa_pkg.sv
package pwa_pkg;

  typedef enum logic [1:0] {
    WM_FULL = 2'b00,
    WM_HALF = 2'b01,
    WM_BYTE = 2'b10,
    WM_RSVD = 2'b11
  } wmode_e;

  // Index of the final piece of a word for a given width mode.
  function automatic logic [1:0] final_piece(wmode_e m);
    case (m)
      WM_HALF: final_piece = 2'd1;
      WM_BYTE: final_piece = 2'd3;
      default: final_piece = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/pwa_mode_track.sv
module pwa_mode_track
  import pwa_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] wsel,
  output wmode_e     mode,
  output logic       chg
);

  logic [1:0] wsel_q;

  always_ff @(posedge clk) begin
    if (rst) wsel_q <= 2'b00;
    else     wsel_q <= wsel;
  end

  assign mode = wmode_e'(wsel);
  assign chg  = (wsel != wsel_q);

endmodule

// File: rtl/pwa_packer.sv
module pwa_packer
  import pwa_pkg::*;
#(
  parameter int WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  wmode_e            mode,
  input  logic              chg,
  input  logic              ext_wr,
  input  logic [WORD_W-1:0] ext_wdata,
  output logic              ext_wr_busy,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  input  logic              out_ready
);

  localparam int LANES  = 4;
  localparam int BYTE_W = WORD_W / LANES;

  logic [1:0]        pos;
  logic              realign_q;
  logic              realign_now;
  logic              accept;
  logic [WORD_W-1:0] acc;
  logic [WORD_W-1:0] next_acc;

  assign ext_wr_busy = out_valid & ~out_ready;
  assign accept      = ext_wr & ~ext_wr_busy;
  assign realign_now = realign_q | (chg & (pos != 2'd0));

  // Steer the incoming piece into its lane(s); untouched lanes keep acc.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_comb begin
      case (mode)
        WM_HALF:
          next_acc[k*BYTE_W +: BYTE_W] = (pos == 2'(k/2))
            ? ext_wdata[(k%2)*BYTE_W +: BYTE_W]
            : acc[k*BYTE_W +: BYTE_W];
        WM_BYTE:
          next_acc[k*BYTE_W +: BYTE_W] = (pos == 2'(k))
            ? ext_wdata[0 +: BYTE_W]
            : acc[k*BYTE_W +: BYTE_W];
        default:
          next_acc[k*BYTE_W +: BYTE_W] = ext_wdata[k*BYTE_W +: BYTE_W];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos       <= 2'd0;
      realign_q <= 1'b0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (accept) begin
        if (realign_now) begin
          pos       <= 2'd0;
          realign_q <= 1'b0;
        end else begin
          acc <= next_acc;
          if (pos == final_piece(mode)) begin
            pos       <= 2'd0;
            out_data  <= next_acc;
            out_valid <= 1'b1;
          end else begin
            pos <= pos + 2'd1;
          end
        end
      end else if (chg && (pos != 2'd0)) begin
        realign_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwa_unpacker.sv
module pwa_unpacker
  import pwa_pkg::*;
#(
  parameter int WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  wmode_e            mode,
  input  logic              chg,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  input  logic              ext_rd,
  output logic [WORD_W-1:0] ext_rdata,
  output logic              ext_rd_busy
);

  localparam int HALF_W = WORD_W / 2;
  localparam int BYTE_W = WORD_W / 4;

  logic              have;
  logic [WORD_W-1:0] word;
  logic [1:0]        pos;
  logic              realign_q;
  logic              realign_now;
  logic              accept;
  logic [WORD_W-1:0] piece;

  assign in_ready    = ~have;
  assign ext_rd_busy = ~have;
  assign accept      = ext_rd & have;
  assign realign_now = realign_q | (chg & (pos != 2'd0));

  always_comb begin
    piece = '0;
    case (mode)
      WM_HALF: piece[HALF_W-1:0] = word[int'(pos[0])*HALF_W +: HALF_W];
      WM_BYTE: piece[BYTE_W-1:0] = word[int'(pos)*BYTE_W +: BYTE_W];
      default: piece = word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      have      <= 1'b0;
      word      <= '0;
      pos       <= 2'd0;
      realign_q <= 1'b0;
      ext_rdata <= '0;
    end else begin
      if (in_valid && !have) begin
        word <= in_data;
        have <= 1'b1;
      end
      if (accept) begin
        if (realign_now) begin
          ext_rdata <= '0;
          have      <= 1'b0;
          pos       <= 2'd0;
          realign_q <= 1'b0;
        end else begin
          ext_rdata <= piece;
          if (pos == final_piece(mode)) begin
            pos  <= 2'd0;
            have <= 1'b0;
          end else begin
            pos <= pos + 2'd1;
          end
        end
      end else if (chg && (pos != 2'd0)) begin
        realign_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/port_width_adapter.sv
module port_width_adapter
  import pwa_pkg::*;
#(
  parameter int WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        wsel,
  input  logic              ext_wr,
  input  logic [WORD_W-1:0] ext_wdata,
  output logic              ext_wr_busy,
  output logic              int_out_valid,
  output logic [WORD_W-1:0] int_out_data,
  input  logic              int_out_ready,
  input  logic              int_in_valid,
  input  logic [WORD_W-1:0] int_in_data,
  output logic              int_in_ready,
  input  logic              ext_rd,
  output logic [WORD_W-1:0] ext_rdata,
  output logic              ext_rd_busy
);

  wmode_e mode;
  logic   chg;

  pwa_mode_track u_mode (
    .clk  (clk),
    .rst  (rst),
    .wsel (wsel),
    .mode (mode),
    .chg  (chg)
  );

  pwa_packer #(.WORD_W(WORD_W)) u_pack (
    .clk         (clk),
    .rst         (rst),
    .mode        (mode),
    .chg         (chg),
    .ext_wr      (ext_wr),
    .ext_wdata   (ext_wdata),
    .ext_wr_busy (ext_wr_busy),
    .out_valid   (int_out_valid),
    .out_data    (int_out_data),
    .out_ready   (int_out_ready)
  );

  pwa_unpacker #(.WORD_W(WORD_W)) u_unpack (
    .clk         (clk),
    .rst         (rst),
    .mode        (mode),
    .chg         (chg),
    .in_valid    (int_in_valid),
    .in_data     (int_in_data),
    .in_ready    (int_in_ready),
    .ext_rd      (ext_rd),
    .ext_rdata   (ext_rdata),
    .ext_rd_busy (ext_rd_busy)
  );

endmodule

// File: rtl/pwa_checker.sv
module pwa_checker #(
  parameter int WORD_W = 36
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        wsel,
  input logic              ext_wr,
  input logic              ext_wr_busy,
  input logic              int_out_valid,
  input logic [WORD_W-1:0] int_out_data,
  input logic              int_out_ready,
  input logic              int_in_valid,
  input logic              int_in_ready,
  input logic              ext_rd,
  input logic [WORD_W-1:0] ext_rdata,
  input logic              ext_rd_busy
);

  localparam int BYTE_W = WORD_W / 4;

  // R1: one cycle after reset the stream sides are idle and ready
  a_r1_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (!int_out_valid && int_in_ready && !ext_wr_busy));

  // R7: stalled packed word is kept, unchanged
  a_r7_hold_word: assert property (@(posedge clk) disable iff (rst)
    (int_out_valid && !int_out_ready) |=> (int_out_valid && $stable(int_out_data)));

  // R6: taking an internal word blocks the next one
  a_r6_take_blocks: assert property (@(posedge clk) disable iff (rst)
    (int_in_valid && int_in_ready) |=> (!int_in_ready && !ext_rd_busy));

  // R12: read with nothing held leaves the read data alone
  a_r12_idle_read: assert property (@(posedge clk) disable iff (rst)
    (ext_rd && ext_rd_busy) |=> $stable(ext_rdata));

  // R5: byte-mode reads carry zeros above the byte lane
  a_r5_byte_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (ext_rd && !ext_rd_busy && wsel == 2'b10) |=> (ext_rdata[WORD_W-1:BYTE_W] == '0));

  // R7: an ignored write strobe never raises a fresh word
  a_r7_no_accept_busy: assert property (@(posedge clk) disable iff (rst)
    (ext_wr && ext_wr_busy) |=> int_out_valid);

endmodule

bind port_width_adapter pwa_checker #(.WORD_W(WORD_W)) u_pwa_chk (
  .clk           (clk),
  .rst           (rst),
  .wsel          (wsel),
  .ext_wr        (ext_wr),
  .ext_wr_busy   (ext_wr_busy),
  .int_out_valid (int_out_valid),
  .int_out_data  (int_out_data),
  .int_out_ready (int_out_ready),
  .int_in_valid  (int_in_valid),
  .int_in_ready  (int_in_ready),
  .ext_rd        (ext_rd),
  .ext_rdata     (ext_rdata),
  .ext_rd_busy   (ext_rd_busy)
);

// File: tb/port_width_adapter_test.sv
`timescale 1ns/1ps
module port_width_adapter_test;

  localparam int W = 36;

  logic         clk = 1'b0;
  logic         rst;
  logic [1:0]   wsel;
  logic         ext_wr;
  logic [W-1:0] ext_wdata;
  logic         ext_wr_busy;
  logic         int_out_valid;
  logic [W-1:0] int_out_data;
  logic         int_out_ready;
  logic         int_in_valid;
  logic [W-1:0] int_in_data;
  logic         int_in_ready;
  logic         ext_rd;
  logic [W-1:0] ext_rdata;
  logic         ext_rd_busy;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  port_width_adapter #(.WORD_W(W)) uut (.*);

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [W-1:0] d);
    @(negedge clk); ext_wr = 1'b1; ext_wdata = d;
    @(negedge clk); ext_wr = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk); ext_rd = 1'b1;
    @(negedge clk); ext_rd = 1'b0;
  endtask

  task automatic push(logic [W-1:0] d);
    @(negedge clk); int_in_valid = 1'b1; int_in_data = d;
    @(negedge clk); int_in_valid = 1'b0;
  endtask

  task automatic set_w(logic [1:0] m);
    @(negedge clk); wsel = m;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 out_valid", W'(int_out_valid), '0);
    check("R1 wr_busy",   W'(ext_wr_busy),   '0);
    check("R1 in_ready",  W'(int_in_ready),  W'(1));
    check("R1 rd_busy",   W'(ext_rd_busy),   W'(1));
    check("R1 rdata",     ext_rdata,         '0);
  endtask

  task automatic t_full_write();
    set_w(2'b00);
    wr(36'h9_8765_4321);
    check("R2 valid", W'(int_out_valid), W'(1));
    check("R2 data",  int_out_data, 36'h9_8765_4321);
    set_w(2'b11);
    wr(36'h1_2345_6789);
    check("R11 data", int_out_data, 36'h1_2345_6789);
  endtask

  task automatic t_half_write();
    set_w(2'b01);  // R8 clean change at boundary
    wr(36'h0_0003_1111);
    check("R3 no early valid", W'(int_out_valid), '0);
    wr(36'h0_0002_2222);
    check("R3 R8 half word", int_out_data, {18'h2_2222, 18'h3_1111});
  endtask

  task automatic t_byte_write();
    set_w(2'b10);
    wr(36'h0_0000_01A1);
    wr(36'h0_0000_00B2);
    wr(36'h0_0000_01C3);
    check("R4 no early valid", W'(int_out_valid), '0);
    wr(36'h0_0000_00D4);
    check("R4 byte word", int_out_data, {9'h0D4, 9'h1C3, 9'h0B2, 9'h1A1});
  endtask

  task automatic t_backpressure();
    set_w(2'b00);
    int_out_ready = 1'b0;
    wr(36'hA_AAAA_0001);
    wr(36'hB_BBBB_0002);
    check("R7 busy",  W'(ext_wr_busy),   W'(1));
    check("R7 held",  int_out_data,      36'hA_AAAA_0001);
    check("R7 valid", W'(int_out_valid), W'(1));
    @(negedge clk); int_out_ready = 1'b1;
    @(negedge clk);
    check("R7 drained", W'(int_out_valid), '0);
    wr(36'hC_CCCC_0003);
    check("R7 next word", int_out_data, 36'hC_CCCC_0003);
  endtask

  task automatic t_realign_write();
    set_w(2'b01);
    wr(36'h0_0001_5555);
    set_w(2'b00);  // mid-word change
    wr(36'hF_FFFF_FFFF);
    check("R9 dummy dropped", W'(int_out_valid), '0);
    wr(36'h3_3333_3333);
    check("R9 full after dummy", int_out_data, 36'h3_3333_3333);
    set_w(2'b10);
    wr(36'h0_0000_0077);
    set_w(2'b01);
    wr(36'h0_0003_FFFF);
    check("R9 half dummy", W'(int_out_valid), '0);
    wr(36'h0_0001_0101);
    wr(36'h0_0002_0202);
    check("R9 half after dummy", int_out_data, {18'h2_0202, 18'h1_0101});
  endtask

  task automatic t_read();
    logic [W-1:0] w;
    w = 36'h4_3210_FEDC;
    set_w(2'b00);
    push(w);
    check("R6 ready low while held", W'(int_in_ready), '0);
    rd();
    check("R5 full read", ext_rdata, w);
    check("R6 ready after last", W'(int_in_ready), W'(1));
    set_w(2'b01);
    push(w);
    rd();
    check("R5 half lo", ext_rdata, W'(w[17:0]));
    check("R6 still held", W'(int_in_ready), '0);
    rd();
    check("R5 half hi", ext_rdata, W'(w[35:18]));
    set_w(2'b10);
    push(w);
    for (int p = 0; p < 4; p++) begin
      rd();
      check("R5 byte", ext_rdata, W'(w[p*9 +: 9]));
    end
    rd();  // nothing held
    check("R12 idle read", ext_rdata, W'(w[35:27]));
  endtask

  task automatic t_realign_read();
    logic [W-1:0] w;
    w = 36'h8_1357_9BDF;
    set_w(2'b10);
    push(w);
    rd();
    check("R10 first byte", ext_rdata, W'(w[8:0]));
    set_w(2'b00);
    rd();
    check("R10 dummy zero", ext_rdata, '0);
    check("R10 word released", W'(int_in_ready), W'(1));
    push(36'h2_4680_ACE1);
    rd();
    check("R10 next word", ext_rdata, 36'h2_4680_ACE1);
  endtask

  initial begin
    rst = 1'b1; wsel = 2'b00; ext_wr = 1'b0; ext_wdata = '0;
    int_out_ready = 1'b1; int_in_valid = 1'b0; int_in_data = '0; ext_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_full_write();
    t_half_write();
    t_byte_write();
    t_backpressure();
    t_realign_write();
    t_read();
    t_realign_read();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule